// File: doc/BRIEF.md
# Four-Channel Byte-Transfer DMA Controller

This block moves single bytes between peripherals and memory on behalf of a CPU over an 8-bit bus. Four request lines come in from peripherals. The CPU first programs each channel's start address, its transfer count and its transfer direction through a small register port. When an enabled channel raises its request, the controller asks for the system bus. Once the CPU grants the bus, the controller becomes bus master and runs one fixed four-clock cycle per byte. During that cycle it drives the memory address, acknowledges the chosen peripheral and pulses one memory strobe and one I/O strobe.

After every byte the controller steps the channel's address up by one and its count down by one. On the last byte of a block it signals terminal count, records that event in a status flag and disables the channel. Contention between channels is resolved either by fixed rank or by a rotating order that is selected in the mode register. The address latches and tri-state pad drivers are left to the surrounding logic. An address-drive enable output stands in for them.

Top module: `dmac_top`

## Requirements
- R1: After reset, `hrq`, `dack`, `addr_oe`, `tc` and all four strobes are low, the status register reads 0, all channels are disabled (a request raises no `hrq`), and the byte pointer selects the low byte.
- R2: Register addresses 0..7 select channel `reg_addr[2:1]`, with the address register when `reg_addr[0]`=0 and the count register when it is 1. Each 16-bit register is accessed as two bytes, low then high, and a shared byte pointer toggles on each such access. Address 8 writes the mode register and reads the status register, and neither access moves the pointer.
- R3: Mode bits 3:0 enable channels 3..0. A request on a disabled channel never raises `hrq`.
- R4: An enabled request raises `hrq`. No acknowledge, address drive or strobe appears until `hlda` has been sampled high.
- R5: A transfer cycle lasts four clocks (S1..S4). During all four, `dack` has the served channel's bit set and `addr_oe` is high, and `mem_addr` equals that channel's address register. Strobes are high only in the second and third clocks.
- R6: While `ready` is low in the third clock, that clock repeats with the strobes held.
- R7: Count bits 15:14 select the strobes: 01 asserts `ior` and `memw`, 10 asserts `memr` and `iow`, and 00 or 11 asserts none.
- R8: Each cycle increments the address register by 1 (with 16-bit carry) and decrements count bits 13:0 by 1 while preserving bits 15:14, so a count field of N-1 yields N cycles.
- R9: `tc` is high throughout the cycle in which the channel's count field is 0. After that cycle the channel's enable bit clears and its status bit sets, so it performs no further cycles.
- R10: Reading address 8 returns the terminal-count flags in bits 3:0 and then clears them.
- R11: With mode bit 4 clear, the lowest-numbered pending channel wins.
- R12: With mode bit 4 set, the channel after the one just served becomes the highest priority, wrapping from 3 to 0.
- R13: While requests remain and `hlda` stays high, cycles follow with no gap. When none remain after a cycle, `hrq` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Register port select, active high |
| wr_stb | input | 1 | Register write strobe, one clock |
| rd_stb | input | 1 | Register read strobe, one clock |
| reg_addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| dreq | input | 4 | Per-channel transfer requests |
| dack | output | 4 | Per-channel acknowledges |
| hrq | output | 1 | Bus hold request |
| hlda | input | 1 | Bus hold granted |
| ready | input | 1 | Low stretches the third cycle clock |
| mem_addr | output | 16 | Memory address of the served channel |
| addr_oe | output | 1 | Address drive enable during a cycle |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal count of the current cycle |

## Verification
The bench builds the block with its defaults of four channels and an 8-bit data bus. At that size a sweep can cover every channel against every transfer type for block lengths of one to three bytes. The start addresses sit just below a low-byte carry, so the sweep also checks the address increment across byte boundaries, the count and address read-back, the terminal-count stop and the self-clearing status. Four channels are also few enough that a complete fixed-rank and rotating grant sequence can be predicted exactly from the channel numbers alone.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S3   = 3'd4,
        ST_S4   = 3'd5
    } dma_st_e;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'b00,
        XF_TO_MEM = 2'b01,
        XF_TO_IO  = 2'b10,
        XF_NONE   = 2'b11
    } xfer_e;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CHW = $clog2(NCH),
    localparam int RA  = CHW + 2,
    localparam int AW  = 2 * DW,
    localparam int CW  = AW - 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_en,
    input  logic                    cs,
    input  logic                    wr_stb,
    input  logic                    rd_stb,
    input  logic [RA-1:0]           reg_addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic [NCH-1:0][AW-1:0]  adr_o,
    output logic [NCH-1:0][AW-1:0]  cnt_o,
    output logic [NCH-1:0]          en_o,
    output logic                    rot_o,
    input  logic                    upd_en,
    input  logic [CHW-1:0]          upd_ch,
    input  logic                    upd_tc
);
    localparam int ROT_BIT = NCH;

    typedef struct packed {
        logic [NCH-1:0][AW-1:0] adr;
        logic [NCH-1:0][AW-1:0] cnt;
        logic [NCH-1:0]         en;
        logic                   rot;
        logic [NCH-1:0]         tcs;
        logic                   ptr;
    } regs_t;

    regs_t q, d;
    logic wr_ok, rd_ok, is_ctl, is_cnt;
    logic [CHW-1:0] sel_ch;
    logic [AW-1:0]  sel_word;

    always_comb begin
        wr_ok    = cs & wr_stb & acc_en;
        rd_ok    = cs & rd_stb & acc_en;
        is_ctl   = reg_addr[RA-1];
        is_cnt   = reg_addr[0];
        sel_ch   = reg_addr[CHW:1];
        sel_word = is_cnt ? q.cnt[sel_ch] : q.adr[sel_ch];

        if (is_ctl) rdata = {{(DW-NCH){1'b0}}, q.tcs};
        else        rdata = q.ptr ? sel_word[AW-1:DW] : sel_word[DW-1:0];

        d = q;
        // status flags clear on read; a terminal event in the same clock wins
        if (rd_ok && is_ctl) d.tcs = '0;
        if (upd_en) begin
            d.adr[upd_ch]         = q.adr[upd_ch] + 1'b1;
            d.cnt[upd_ch][CW-1:0] = q.cnt[upd_ch][CW-1:0] - 1'b1;
            if (upd_tc) begin
                d.en[upd_ch]  = 1'b0;
                d.tcs[upd_ch] = 1'b1;
            end
        end
        if (wr_ok) begin
            if (is_ctl) begin
                d.en  = wdata[NCH-1:0];
                d.rot = wdata[ROT_BIT];
            end else begin
                if (is_cnt) begin
                    if (q.ptr) d.cnt[sel_ch][AW-1:DW] = wdata;
                    else       d.cnt[sel_ch][DW-1:0]  = wdata;
                end else begin
                    if (q.ptr) d.adr[sel_ch][AW-1:DW] = wdata;
                    else       d.adr[sel_ch][DW-1:0]  = wdata;
                end
                d.ptr = ~q.ptr;
            end
        end
        if (rd_ok && !is_ctl) d.ptr = ~q.ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign adr_o = q.adr;
    assign cnt_o = q.cnt;
    assign en_o  = q.en;
    assign rot_o = q.rot;

    // R8: count field steps down by one per cycle
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> q.cnt[$past(upd_ch)][CW-1:0] == CW'($past(q.cnt[upd_ch][CW-1:0]) - 1'b1));

    // R9: terminal cycle disables the channel and flags it
    p_tc_disables_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_tc) |=> (!q.en[$past(upd_ch)] && q.tcs[$past(upd_ch)]));

    // R10: a status read with no terminal event leaves all flags clear
    p_status_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && is_ctl && !upd_en) |=> (q.tcs == '0));
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  req,
    input  logic            rot,
    input  logic [CHW-1:0]  last,
    output logic [CHW-1:0]  gnt,
    output logic            any
);
    logic [CHW-1:0] base, idx;
    logic [NCH-1:0] below;

    always_comb begin
        base = rot ? CHW'(last + 1'b1) : '0;
        gnt  = '0;
        any  = 1'b0;
        idx  = '0;
        for (int k = 0; k < NCH; k++) begin
            idx = CHW'(base + CHW'(k));
            if (!any && req[idx]) begin
                any = 1'b1;
                gnt = idx;
            end
        end
        below = req & ((NCH'(1) << gnt) - NCH'(1));
    end

    // R11: a grant always points at a live request
    p_grant_live_r11: assert property (@(posedge clk) disable iff (rst)
        any |-> req[gnt]);

    // R11: in fixed rank no lower-numbered channel is waiting
    p_fixed_lowest_r11: assert property (@(posedge clk) disable iff (rst)
        (any && !rot) |-> (below == '0));
endmodule

// File: rtl/dmac_eng.sv
module dmac_eng
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    localparam int CHW = $clog2(NCH),
    localparam int CW  = AW - 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          pend,
    input  logic                    rot,
    input  logic [NCH-1:0][AW-1:0]  adr_all,
    input  logic [NCH-1:0][AW-1:0]  cnt_all,
    input  logic                    hlda,
    input  logic                    ready,
    output logic                    hrq,
    output logic [NCH-1:0]          dack,
    output logic                    addr_oe,
    output logic [AW-1:0]           mem_addr,
    output logic                    ior,
    output logic                    iow,
    output logic                    memr,
    output logic                    memw,
    output logic                    tc,
    output logic                    idle,
    output logic                    upd_en,
    output logic [CHW-1:0]          upd_ch,
    output logic                    upd_tc
);
    typedef struct packed {
        dma_st_e        st;
        logic           hrq;
        logic [CHW-1:0] ch;
        logic [CHW-1:0] last;
    } eng_t;

    eng_t q, d;
    logic [AW-1:0]  cur_cnt;
    logic           term, in_cyc, stb;
    xfer_e          typ;
    logic [NCH-1:0] kill, arb_req;
    logic [CHW-1:0] arb_last, gnt;
    logic           any;

    dmac_arb #(.NCH(NCH)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (arb_req),
        .rot (rot),
        .last(arb_last),
        .gnt (gnt),
        .any (any)
    );

    always_comb begin
        cur_cnt  = cnt_all[q.ch];
        term     = (cur_cnt[CW-1:0] == '0);
        typ      = xfer_e'(cur_cnt[AW-1:CW]);
        in_cyc   = (q.st == ST_S1) || (q.st == ST_S2) || (q.st == ST_S3) || (q.st == ST_S4);
        stb      = (q.st == ST_S2) || (q.st == ST_S3);
        // a channel finishing its block this clock must not win the next slot
        kill     = (q.st == ST_S4 && term) ? (NCH'(1) << q.ch) : '0;
        arb_req  = pend & ~kill;
        arb_last = (q.st == ST_S4) ? q.ch : q.last;

        d = q;
        case (q.st)
            ST_IDLE: begin
                if (any) begin
                    d.hrq = 1'b1;
                    d.st  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!any) begin
                    d.hrq = 1'b0;
                    d.st  = ST_IDLE;
                end else if (hlda) begin
                    d.ch = gnt;
                    d.st = ST_S1;
                end
            end
            ST_S1: d.st = ST_S2;
            ST_S2: d.st = ST_S3;
            ST_S3: if (ready) d.st = ST_S4;
            ST_S4: begin
                d.last = q.ch;
                if (any) begin
                    if (hlda) begin
                        d.ch = gnt;
                        d.st = ST_S1;
                    end else begin
                        d.st = ST_HOLD;
                    end
                end else begin
                    d.hrq = 1'b0;
                    d.st  = ST_IDLE;
                end
            end
            default: begin
                d.hrq = 1'b0;
                d.st  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: ST_IDLE, hrq: 1'b0, ch: '0, last: CHW'(NCH - 1)};
        else     q <= d;
    end

    assign hrq      = q.hrq;
    assign dack     = in_cyc ? (NCH'(1) << q.ch) : '0;
    assign addr_oe  = in_cyc;
    assign mem_addr = adr_all[q.ch];
    assign ior      = stb && (typ == XF_TO_MEM);
    assign memw     = stb && (typ == XF_TO_MEM);
    assign memr     = stb && (typ == XF_TO_IO);
    assign iow      = stb && (typ == XF_TO_IO);
    assign tc       = in_cyc && term;
    assign idle     = (q.st == ST_IDLE);
    assign upd_en   = (q.st == ST_S4);
    assign upd_ch   = q.ch;
    assign upd_tc   = term;

    // R4: bus ownership starts only after the grant was seen
    p_owns_after_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe) |-> $past(hlda));

    // R4: address drive only while the hold request is up
    p_drive_under_hold_r4: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> hrq);

    // R5: at most one channel acknowledged
    p_single_ack_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R6: a low ready keeps the strobes and the address where they are
    p_wait_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_S3 && !ready) |=> (stb && $stable(mem_addr) && $stable(dack)));

    // R7: never both memory strobes nor both I/O strobes
    p_strobe_pair_r7: assert property (@(posedge clk) disable iff (rst)
        !(memr && memw) && !(ior && iow));
endmodule

// File: rtl/dmac_top.sv
module dmac_top #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int RA = $clog2(NCH) + 2,
    localparam int AW = 2 * DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic [RA-1:0]   reg_addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NCH-1:0]  dreq,
    output logic [NCH-1:0]  dack,
    output logic            hrq,
    input  logic            hlda,
    input  logic            ready,
    output logic [AW-1:0]   mem_addr,
    output logic            addr_oe,
    output logic            ior,
    output logic            iow,
    output logic            memr,
    output logic            memw,
    output logic            tc
);
    localparam int CHW = $clog2(NCH);

    logic [NCH-1:0][AW-1:0] adr_all, cnt_all;
    logic [NCH-1:0]         en;
    logic                   rot, idle, upd_en, upd_tc;
    logic [CHW-1:0]         upd_ch;
    logic [NCH-1:0]         pend;

    assign pend = dreq & en;

    dmac_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .acc_en  (idle),
        .cs      (cs),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .reg_addr(reg_addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .adr_o   (adr_all),
        .cnt_o   (cnt_all),
        .en_o    (en),
        .rot_o   (rot),
        .upd_en  (upd_en),
        .upd_ch  (upd_ch),
        .upd_tc  (upd_tc)
    );

    dmac_eng #(.NCH(NCH), .AW(AW)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .rot     (rot),
        .adr_all (adr_all),
        .cnt_all (cnt_all),
        .hlda    (hlda),
        .ready   (ready),
        .hrq     (hrq),
        .dack    (dack),
        .addr_oe (addr_oe),
        .mem_addr(mem_addr),
        .ior     (ior),
        .iow     (iow),
        .memr    (memr),
        .memw    (memw),
        .tc      (tc),
        .idle    (idle),
        .upd_en  (upd_en),
        .upd_ch  (upd_ch),
        .upd_tc  (upd_tc)
    );

    // R3: no hold request while nothing enabled is requesting and the engine is idle
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (idle && pend == '0) |=> !hrq);
endmodule

// File: tb/dmac_top_test.sv
`timescale 1ns/1ps
module dmac_top_test;
    logic        clk = 1'b0;
    logic        rst, cs, wr_stb, rd_stb, hlda, ready;
    logic [3:0]  reg_addr, dreq, dack;
    logic [7:0]  wdata, rdata;
    logic        hrq, addr_oe, ior, iow, memr, memw, tc;
    logic [15:0] mem_addr;
    logic        hlda_en;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    int          n_cyc, aoe_cnt, tnow;
    logic [3:0]  log_dk [64];
    logic [15:0] log_adr[64];
    logic        log_tc [64];
    logic [3:0]  log_s0 [64];
    logic [3:0]  log_s1 [64];
    int          log_t  [64];

    always #2.5 clk = ~clk;

    dmac_top uut (
        .clk(clk), .rst(rst), .cs(cs), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .dreq(dreq),
        .dack(dack), .hrq(hrq), .hlda(hlda), .ready(ready), .mem_addr(mem_addr),
        .addr_oe(addr_oe), .ior(ior), .iow(iow), .memr(memr), .memw(memw), .tc(tc)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // bus owner model: grants the bus one half-clock after the request
    initial begin
        hlda = 1'b0;
        forever begin
            @(negedge clk);
            hlda = hrq & hlda_en;
        end
    end

    // cycle monitor: with ready high every cycle spans four address-drive clocks
    initial begin
        tnow = 0;
        forever begin
            @(negedge clk);
            tnow++;
            if (addr_oe && n_cyc < 64) begin
                case (aoe_cnt % 4)
                    0: begin
                        log_dk[n_cyc]  = dack;
                        log_adr[n_cyc] = mem_addr;
                        log_tc[n_cyc]  = tc;
                        log_s0[n_cyc]  = {ior, iow, memr, memw};
                        log_t[n_cyc]   = tnow;
                    end
                    1: log_s1[n_cyc] = {ior, iow, memr, memw};
                    3: n_cyc++;
                    default: ;
                endcase
                aoe_cnt++;
            end
        end
    end

    task automatic clear_log();
        n_cyc   = 0;
        aoe_cnt = 0;
    endtask

    task automatic cpu_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        cs = 1; wr_stb = 1; reg_addr = a; wdata = v;
        @(negedge clk);
        cs = 0; wr_stb = 0;
    endtask

    task automatic cpu_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        cs = 1; rd_stb = 1; reg_addr = a;
        #1 v = rdata;
        @(negedge clk);
        cs = 0; rd_stb = 0;
    endtask

    task automatic prog_ch(input int c, input logic [15:0] adr, input logic [15:0] cnt);
        cpu_write(4'(2*c), adr[7:0]);
        cpu_write(4'(2*c), adr[15:8]);
        cpu_write(4'(2*c+1), cnt[7:0]);
        cpu_write(4'(2*c+1), cnt[15:8]);
    endtask

    task automatic read16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        cpu_read(a, lo);
        cpu_read(a, hi);
        v = {hi, lo};
    endtask

    task automatic wait_done(input int n);
        int k;
        k = 0;
        while (!((n_cyc >= n) && !hrq && !addr_oe) && k < 600) begin
            @(negedge clk);
            k++;
        end
        check(k < 600, "R13 completion timeout", 32'(n_cyc), 32'(n));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] w, base;
        logic [1:0]  typ;
        logic [3:0]  exp_stb;
        int          wd;

        rst = 1; cs = 0; wr_stb = 0; rd_stb = 0; reg_addr = 0; wdata = 0;
        dreq = 0; ready = 1; hlda_en = 1;
        clear_log();
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        check(!hrq && !addr_oe && !tc, "R1 control outputs idle", {hrq, addr_oe, tc}, 0);
        check(dack == 0, "R1 dack idle", dack, 0);
        check({ior, iow, memr, memw} == 0, "R1 strobes idle", {ior, iow, memr, memw}, 0);
        cpu_read(4'd8, b);
        check(b == 0, "R1 status after reset", b, 0);
        prog_ch(0, 16'h0100, 16'h4000);
        dreq = 4'b0001;
        repeat (10) @(negedge clk);
        check(!hrq, "R1 channels disabled by reset", hrq, 0);
        dreq = 0;
        cpu_write(4'd0, 8'hAA);
        do_reset();
        cpu_write(4'd0, 8'h34);
        cpu_write(4'd0, 8'h12);
        read16(4'd0, w);
        check(w == 16'h1234, "R1 byte pointer cleared by reset", w, 16'h1234);

        // R2 mode access leaves the byte pointer alone; count and address are distinct
        cpu_write(4'd4, 8'h78);
        cpu_write(4'd8, 8'h00);
        cpu_write(4'd4, 8'h56);
        cpu_write(4'd5, 8'hCD);
        cpu_write(4'd5, 8'hAB);
        read16(4'd4, w);
        check(w == 16'h5678, "R2 address readback", w, 16'h5678);
        read16(4'd5, w);
        check(w == 16'hABCD, "R2 count readback", w, 16'hABCD);

        // R3 masked request
        prog_ch(1, 16'h0200, 16'h4000);
        cpu_write(4'd8, 8'h02);
        dreq = 4'b0001;
        repeat (10) @(negedge clk);
        check(!hrq && dack == 0, "R3 masked channel raises nothing", {hrq, dack}, 0);
        dreq = 0;
        cpu_write(4'd8, 8'h00);

        // R4 no ownership before grant
        hlda_en = 0;
        prog_ch(3, 16'h0300, 16'h4000);
        clear_log();
        cpu_write(4'd8, 8'h08);
        dreq = 4'b1000;
        repeat (6) @(negedge clk);
        check(hrq, "R4 hold requested", hrq, 1);
        check(!addr_oe && dack == 0 && {ior, iow, memr, memw} == 0,
              "R4 no drive before grant", {addr_oe, dack}, 0);
        hlda_en = 1;
        wait_done(1);
        check(n_cyc == 1 && log_dk[0] == 4'b1000, "R4 cycle after grant", log_dk[0], 4'b1000);
        dreq = 0;
        cpu_read(4'd8, b);

        // sweep: channel x type x length
        for (int c = 0; c < 4; c++) begin
            for (int t = 0; t < 3; t++) begin
                for (int n = 1; n <= 3; n++) begin
                    typ     = (t == 0) ? 2'b01 : (t == 1) ? 2'b10 : 2'b00;
                    exp_stb = (t == 0) ? 4'b1001 : (t == 1) ? 4'b0110 : 4'b0000;
                    base    = 16'h10FE + 16'(c) * 16'h1000;
                    prog_ch(c, base, {typ, 14'(n - 1)});
                    clear_log();
                    cpu_write(4'd8, 8'(1 << c));
                    dreq[c] = 1'b1;
                    wait_done(n);
                    repeat (8) @(negedge clk);
                    check(n_cyc == n, "R9 channel stops at terminal count", 32'(n_cyc), 32'(n));
                    check(!hrq, "R13 hold released", hrq, 0);
                    dreq = 0;
                    for (int i = 0; i < n; i++) begin
                        check(log_dk[i] == 4'(1 << c), "R5 acknowledge channel", log_dk[i], 4'(1 << c));
                        check(log_adr[i] == base + 16'(i), "R5 address on bus", log_adr[i], base + 16'(i));
                        check(log_tc[i] == (i == n - 1), "R9 terminal count flag", log_tc[i], (i == n - 1));
                        check(log_s0[i] == 0, "R5 strobes low in first clock", log_s0[i], 0);
                        check(log_s1[i] == exp_stb, "R7 strobe pair", log_s1[i], exp_stb);
                        if (i > 0)
                            check(log_t[i] - log_t[i-1] == 4, "R13 back-to-back spacing",
                                  32'(log_t[i] - log_t[i-1]), 4);
                    end
                    cpu_read(4'd8, b);
                    check(b == 8'(1 << c), "R10 status flag set", b, 8'(1 << c));
                    cpu_read(4'd8, b);
                    check(b == 0, "R10 status cleared by read", b, 0);
                    read16(4'(2*c), w);
                    check(w == base + 16'(n), "R8 address advanced", w, base + 16'(n));
                    read16(4'(2*c+1), w);
                    check(w == {typ, 14'h3FFF}, "R8 count stepped, type kept", w, {typ, 14'h3FFF});
                end
            end
        end

        // R6 wait states
        prog_ch(1, 16'h3000, 16'h8000);
        clear_log();
        ready = 0;
        cpu_write(4'd8, 8'h02);
        dreq = 4'b0010;
        wd = 0;
        while (!memr && wd < 100) begin
            @(negedge clk);
            wd++;
        end
        wd = 0;
        while (memr && wd < 50) begin
            wd++;
            if (wd == 6) ready = 1;
            @(negedge clk);
        end
        check(wd == 6, "R6 ready low stretches strobe", 32'(wd), 6);
        check(mem_addr == 16'h3000, "R6 address held through wait", mem_addr, 16'h3000);
        ready = 1;
        repeat (6) @(negedge clk);
        dreq = 0;
        cpu_read(4'd8, b);
        check(b == 8'h02, "R6 cycle completed after wait", b, 8'h02);

        // R11 fixed priority
        for (int c = 0; c < 4; c++) prog_ch(c, 16'h2000 + 16'(c) * 16'h100, {2'b01, 14'd7});
        clear_log();
        cpu_write(4'd8, 8'h0F);
        dreq = 4'hF;
        wait_done(32);
        dreq = 0;
        check(n_cyc == 32, "R11 all blocks done", 32'(n_cyc), 32);
        for (int i = 0; i < 10; i++)
            check(log_dk[i] == ((i < 8) ? 4'b0001 : 4'b0010), "R11 fixed order",
                  log_dk[i], ((i < 8) ? 4'b0001 : 4'b0010));
        cpu_read(4'd8, b);
        check(b == 8'h0F, "R10 all flags", b, 8'h0F);

        // R12 rotating priority
        for (int c = 0; c < 4; c++) prog_ch(c, 16'h2000 + 16'(c) * 16'h100, {2'b10, 14'd7});
        clear_log();
        cpu_write(4'd8, 8'h1F);
        dreq = 4'hF;
        wait_done(32);
        dreq = 0;
        for (int i = 0; i < 16; i++)
            check(log_dk[i] == 4'(1 << (i % 4)), "R12 rotating order", log_dk[i], 4'(1 << (i % 4)));
        cpu_read(4'd8, b);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule